// File: doc/BRIEF.md
# Triggered Capture Stream Controller

This block sits between a two-channel ADC sample source and a downstream write FIFO. It lets sample pairs through only after a host has started a transfer, armed the trigger path, and an external trigger edge has arrived. Each accepted trigger opens a burst with a fixed number of sample pairs. The block writes the burst as one interleaved word stream: the channel-0 word first, then the channel-1 word, and each word carries a tag bit that names its channel.

The host picks one of two transfer modes. A finite run ends on its own after a programmed number of bursts. A continuous run goes on until the host asks it to stop, and a stop only takes effect once the current burst has finished. The block watches the FIFO flags. A write into a full FIFO, or a read from an empty FIFO during a continuous run, moves the block into a sticky error state. Only an explicit clear takes it out of that state. Triggers that arrive while a burst is still busy are dropped, and a saturating counter records how many were dropped.

Top module: `trig_capture_stream`

## Requirements
- R1: `state_o` encodes the controller state as 0 = idle, 1 = finite run, 2 = continuous run, 3 = error. After reset the state is idle, `out_valid_o` is 0 and `missed_o` is 0.
- R2: `out_valid_o` is high only while `state_o` is 1 or 2. Triggers seen in idle produce no words.
- R3: No word is written before a trigger is accepted. Sample pairs that arrive before the accepted trigger are dropped.
- R4: A trigger is accepted only on a rising edge of `ext_trig_i` while `arm_i` is high during a run. A pulse on `trig_reset_i` discards an accepted trigger that has not yet started its burst.
- R5: Each burst holds `BURST_LEN` sample pairs (800 by default). For each pair the block writes the channel-0 word with `out_tag_o` = 0, then the channel-1 word with `out_tag_o` = 1, giving 2·`BURST_LEN` words per burst.
- R6: `start_finite_i` in idle with a nonzero `total_bursts_i` starts a finite run. The run writes exactly that many complete bursts and then returns to idle on its own.
- R7: `start_cont_i` in idle starts a continuous run. The run accepts triggers until `stop_i`, and returns to idle only after the burst in progress has finished, so every burst is written as a whole frame.
- R8: A word presented on `out_valid_o` while `fifo_full_i` is high puts the block into error on the next cycle.
- R9: A read request (`fifo_rd_i`) while `fifo_empty_i` is high puts the block into error during a continuous run. During a finite run the same condition has no effect.
- R10: The error state persists, with no words written, until `err_clear_i` is pulsed. The clear returns the block to idle.
- R11: A trigger edge that arrives while armed during a run, with a burst active or a trigger pending, is ignored and increments `missed_o` (saturating). Accepting a start command clears `missed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_finite_i | input | 1 | Start a finite run (pulse, honoured in idle) |
| start_cont_i | input | 1 | Start a continuous run (pulse, honoured in idle) |
| stop_i | input | 1 | Request stop at the next burst boundary |
| total_bursts_i | input | CNT_W | Number of bursts in a finite run |
| arm_i | input | 1 | Ready-for-trigger enable from the host |
| trig_reset_i | input | 1 | Discard a pending accepted trigger |
| err_clear_i | input | 1 | Return to idle from any state |
| ext_trig_i | input | 1 | External hardware trigger level |
| adc_valid_i | input | 1 | Sample pair strobe (never two cycles in a row) |
| adc_ch0_i | input | DATA_W | Channel-0 sample |
| adc_ch1_i | input | DATA_W | Channel-1 sample |
| fifo_full_i | input | 1 | Downstream FIFO full flag |
| fifo_empty_i | input | 1 | Downstream FIFO empty flag |
| fifo_rd_i | input | 1 | Downstream read request |
| out_data_o | output | DATA_W | Word to the FIFO |
| out_tag_o | output | 1 | Channel of the word (0 or 1) |
| out_valid_o | output | 1 | Write strobe to the FIFO |
| state_o | output | 2 | Controller state, encoded per R1 |
| missed_o | output | MISS_W | Count of ignored trigger edges |

## Verification
A table of runs covers the main function. Finite runs with one, three and five bursts show whether the block counts bursts correctly and stops by itself. Continuous runs with two and four triggers followed by a stop show that the stop is held back to the frame boundary. Triggers spaced at different gaps show whether a burst is sized by its sample count rather than by trigger timing. Directed cases separate the gating conditions from one another: a trigger in idle, a run with no trigger, a trigger while disarmed, a trigger cancelled before its first sample, a trigger during a burst, and full and empty flags in each mode.

// File: rtl/tcs_pkg.sv
// Package: shared state encoding for the triggered capture stream controller.
// Assumes: the 2-bit encoding is visible to the host on state_o.
package tcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIN  = 2'd1,
        ST_CONT = 2'd2,
        ST_ERR  = 2'd3
    } tcs_state_e;
endpackage

// File: rtl/tcs_trig_gate.sv
// Trigger gate: detects rising edges of the external trigger, holds one
// accepted trigger until the burst engine consumes it, and counts edges
// that arrive while the engine is busy.
// Assumes: ext_trig_i is already synchronous to clk.
module tcs_trig_gate #(
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live_i,      // a run is in progress
    input  logic              accept_ok_i, // new bursts still allowed
    input  logic              clear_i,     // start command accepted
    input  logic              arm_i,
    input  logic              ext_trig_i,
    input  logic              trig_reset_i,
    input  logic              busy_i,      // burst engine busy
    input  logic              consume_i,   // burst engine took the trigger
    output logic              pend_o,
    output logic [MISS_W-1:0] missed_o
);
    logic              trig_q;
    logic              pend_q;
    logic [MISS_W-1:0] missed_q;
    logic              rise;
    logic              accept;
    logic              miss;

    assign rise   = ext_trig_i && !trig_q;
    assign accept = live_i && accept_ok_i && arm_i && rise && !busy_i && !pend_q;
    assign miss   = live_i && arm_i && rise && (busy_i || pend_q);

    // Remember the previous trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= ext_trig_i;
    end

    // Hold an accepted trigger until it is used or discarded.
    always_ff @(posedge clk) begin
        if (!rst_n || !live_i) pend_q <= 1'b0;
        else if (trig_reset_i) pend_q <= 1'b0;
        else if (accept)       pend_q <= 1'b1;
        else if (consume_i)    pend_q <= 1'b0;
    end

    // Count ignored trigger edges, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)            missed_q <= '0;
        else if (miss && missed_q != '1)  missed_q <= missed_q + MISS_W'(1);
    end

    assign pend_o   = pend_q;
    assign missed_o = missed_q;

    a_r4_pend_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(arm_i));

    a_r11_missed_step: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && missed_q != '1) |=> (missed_q == $past(missed_q) + MISS_W'(1)));
endmodule

// File: rtl/tcs_burst_pack.sv
// Burst packer: once a trigger is pending, takes BURST_LEN sample pairs and
// writes each pair as two words, channel 0 first, with a channel tag.
// Assumes: adc_valid_i is never high on two consecutive cycles; a strobe
// that arrives while the channel-1 word is still being written is dropped.
module tcs_burst_pack #(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,    // not in a run: drop all state
    input  logic              start_ok_i, // trigger pending
    input  logic              adc_valid_i,
    input  logic [DATA_W-1:0] adc_ch0_i,
    input  logic [DATA_W-1:0] adc_ch1_i,
    output logic [DATA_W-1:0] word_o,
    output logic              tag_o,
    output logic              wr_o,
    output logic              busy_o,
    output logic              consume_o,
    output logic              end_o
);
    localparam int IDX_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

    logic              active_q;
    logic              odd_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] word_q;
    logic              tag_q;
    logic              wr_q;
    logic              take;
    logic              last;

    assign take = adc_valid_i && !odd_q && (active_q || start_ok_i);
    assign last = take && (idx_q == LAST_IDX);

    // Pair sequencer: write channel 0 on take, channel 1 on the cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            active_q <= 1'b0;
            odd_q    <= 1'b0;
            idx_q    <= '0;
            hold_q   <= '0;
            word_q   <= '0;
            tag_q    <= 1'b0;
            wr_q     <= 1'b0;
        end else if (take) begin
            word_q   <= adc_ch0_i;
            tag_q    <= 1'b0;
            wr_q     <= 1'b1;
            hold_q   <= adc_ch1_i;
            odd_q    <= 1'b1;
            idx_q    <= last ? '0 : idx_q + IDX_W'(1);
            active_q <= !last;
        end else if (odd_q) begin
            word_q   <= hold_q;
            tag_q    <= 1'b1;
            wr_q     <= 1'b1;
            odd_q    <= 1'b0;
        end else begin
            wr_q     <= 1'b0;
        end
    end

    assign word_o    = word_q;
    assign tag_o     = tag_q;
    assign wr_o      = wr_q;
    assign busy_o    = active_q || odd_q;
    assign consume_o = take && !active_q;
    assign end_o     = last;

    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (idx_q <= LAST_IDX));

    a_r5_ch1_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_q && !flush_i) |=> (wr_q && tag_q));
endmodule

// File: rtl/trig_capture_stream.sv
// Triggered capture stream controller: run-mode state machine (idle, finite,
// continuous, error), burst counting, stop at frame boundaries and FIFO
// error detection around the trigger gate and burst packer.
// Assumes: all inputs are synchronous to clk; host commands are pulses.
module trig_capture_stream
    import tcs_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 800,
    parameter int CNT_W     = 16,
    parameter int MISS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_finite_i,
    input  logic              start_cont_i,
    input  logic              stop_i,
    input  logic [CNT_W-1:0]  total_bursts_i,
    input  logic              arm_i,
    input  logic              trig_reset_i,
    input  logic              err_clear_i,
    input  logic              ext_trig_i,
    input  logic              adc_valid_i,
    input  logic [DATA_W-1:0] adc_ch0_i,
    input  logic [DATA_W-1:0] adc_ch1_i,
    input  logic              fifo_full_i,
    input  logic              fifo_empty_i,
    input  logic              fifo_rd_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_tag_o,
    output logic              out_valid_o,
    output logic [1:0]        state_o,
    output logic [MISS_W-1:0] missed_o
);
    tcs_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q;
    logic             stop_q;
    logic             live;
    logic             accept_ok;
    logic             start_cmd;
    logic             pend;
    logic             busy;
    logic             consume;
    logic             burst_end;
    logic             wr;
    logic             quiet;
    logic             ovf;
    logic             unf;

    assign live      = (state_q == ST_FIN) || (state_q == ST_CONT);
    assign accept_ok = !stop_q && !((state_q == ST_FIN) && (left_q == '0));
    assign start_cmd = (state_q == ST_IDLE) && !err_clear_i &&
                       ((start_finite_i && total_bursts_i != '0) || start_cont_i);
    assign quiet     = !pend && !busy;
    assign out_valid_o = wr && live;
    assign ovf       = out_valid_o && fifo_full_i;
    assign unf       = (state_q == ST_CONT) && fifo_rd_i && fifo_empty_i;

    tcs_trig_gate #(.MISS_W(MISS_W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .live_i       (live),
        .accept_ok_i  (accept_ok),
        .clear_i      (start_cmd),
        .arm_i        (arm_i),
        .ext_trig_i   (ext_trig_i),
        .trig_reset_i (trig_reset_i),
        .busy_i       (busy),
        .consume_i    (consume),
        .pend_o       (pend),
        .missed_o     (missed_o)
    );

    tcs_burst_pack #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (!live),
        .start_ok_i  (pend),
        .adc_valid_i (adc_valid_i),
        .adc_ch0_i   (adc_ch0_i),
        .adc_ch1_i   (adc_ch1_i),
        .word_o      (out_data_o),
        .tag_o       (out_tag_o),
        .wr_o        (wr),
        .busy_o      (busy),
        .consume_o   (consume),
        .end_o       (burst_end)
    );

    // Next-state logic of the run-mode machine.
    always_comb begin
        state_d = state_q;
        if (err_clear_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_finite_i && total_bursts_i != '0) state_d = ST_FIN;
                    else if (start_cont_i)                      state_d = ST_CONT;
                end
                ST_FIN, ST_CONT: begin
                    if (ovf || unf)
                        state_d = ST_ERR;
                    else if (quiet && (stop_q || (state_q == ST_FIN && left_q == '0)))
                        state_d = ST_IDLE;
                end
                default: state_d = ST_ERR;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remaining bursts of a finite run.
    always_ff @(posedge clk) begin
        if (!rst_n)                                left_q <= '0;
        else if (start_cmd && start_finite_i)      left_q <= total_bursts_i;
        else if (burst_end && state_q == ST_FIN && left_q != '0)
                                                   left_q <= left_q - CNT_W'(1);
    end

    // Stop request held until the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !live) stop_q <= 1'b0;
        else if (stop_i)     stop_q <= 1'b1;
    end

    assign state_o = state_q;

    a_r8_overflow_err: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && fifo_full_i && !err_clear_i) |=> (state_q == ST_ERR));

    a_r9_underflow_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONT && fifo_rd_i && fifo_empty_i && !err_clear_i)
        |=> (state_q == ST_ERR));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR && !err_clear_i) |=> (state_q == ST_ERR));

    a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_tag_o && !ovf && !unf && !err_clear_i)
        |=> (out_valid_o && out_tag_o));
endmodule

// File: tb/trig_capture_stream_bench.sv
module trig_capture_stream_bench;
    localparam int DW = 16;
    localparam int BL = 4;
    localparam int CW = 16;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_finite = 1'b0, start_cont = 1'b0, stop = 1'b0;
    logic [CW-1:0] total = '0;
    logic          arm = 1'b0, trig_reset = 1'b0, err_clear = 1'b0, ext_trig = 1'b0;
    logic          adc_valid = 1'b0;
    logic [DW-1:0] ch0 = '0, ch1 = '0;
    logic          fifo_full = 1'b0, fifo_empty = 1'b0, fifo_rd = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_tag, out_valid;
    logic [1:0]    state;
    logic [MW-1:0] missed;

    trig_capture_stream #(.DATA_W(DW), .BURST_LEN(BL), .CNT_W(CW), .MISS_W(MW))
    u_trig_capture_stream (
        .clk(clk), .rst_n(rst_n), .start_finite_i(start_finite),
        .start_cont_i(start_cont), .stop_i(stop), .total_bursts_i(total),
        .arm_i(arm), .trig_reset_i(trig_reset), .err_clear_i(err_clear),
        .ext_trig_i(ext_trig), .adc_valid_i(adc_valid), .adc_ch0_i(ch0),
        .adc_ch1_i(ch1), .fifo_full_i(fifo_full), .fifo_empty_i(fifo_empty),
        .fifo_rd_i(fifo_rd), .out_data_o(out_data), .out_tag_o(out_tag),
        .out_valid_o(out_valid), .state_o(state), .missed_o(missed)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int words = 0;
    int mon_err = 0;
    logic exp_tag = 1'b0;
    logic [DW-1:0] last0 = '0;
    logic gen_en = 1'b0;
    logic done = 1'b0;

    // [16] continuous, [15:8] bursts or triggers, [7:0] gap cycles
    localparam logic [16:0] RUNS [5] = '{
        {1'b0, 8'd1, 8'd20},
        {1'b0, 8'd3, 8'd20},
        {1'b1, 8'd2, 8'd25},
        {1'b0, 8'd5, 8'd30},
        {1'b1, 8'd4, 8'd20}
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic clr_mon();
        @(negedge clk);
        words = 0; mon_err = 0; exp_tag = 1'b0;
    endtask

    // Sample source: a pair every other cycle, ch1 = ch0 + 0x4000.
    initial begin
        logic [DW-1:0] seq = '0;
        forever begin
            @(negedge clk);
            if (gen_en && !adc_valid) begin
                adc_valid = 1'b1;
                seq = (seq + 16'd1) & 16'h3fff;
                ch0 = seq;
                ch1 = seq + 16'h4000;
            end else begin
                adc_valid = 1'b0;
            end
        end
    end

    // Output monitor: word count, tag order (R5), data pairing, gating (R2).
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                words++;
                if (state != 2'd1 && state != 2'd2) mon_err++;
                if (out_tag != exp_tag) mon_err++;
                if (!out_tag) last0 = out_data;
                else if (out_data != last0 + 16'h4000) mon_err++;
                exp_tag = ~exp_tag;
            end
        end
    end

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check(state == 2'd0, "R1 reset state", state, 0);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(missed == '0, "R1 reset missed", missed, 0);
        gen_en = 1'b1;

        // Table of runs: R5 R6 R7
        for (int i = 0; i < 5; i++) begin
            logic cont;
            int   nb, gap;
            cont = RUNS[i][16];
            nb   = int'(RUNS[i][15:8]);
            gap  = int'(RUNS[i][7:0]);
            clr_mon();
            arm = 1'b1;
            total = CW'(nb);
            if (cont) pulse(start_cont); else pulse(start_finite);
            for (int b = 0; b < nb; b++) begin
                pulse(ext_trig);
                cycles(gap);
            end
            if (cont) begin
                check(state == 2'd2, "R7 still running", state, 2);
                pulse(stop);
            end
            cycles(10);
            check(words == 2 * BL * nb, cont ? "R7 frame words" : "R6 finite words", words, 2 * BL * nb);
            check(state == 2'd0, cont ? "R7 back to idle" : "R6 back to idle", state, 0);
            check(mon_err == 0, "R5 interleave order", mon_err, 0);
        end

        // R2: triggers in idle write nothing
        clr_mon();
        pulse(ext_trig);
        cycles(20);
        check(words == 0, "R2 idle no words", words, 0);

        // R3: continuous run without trigger writes nothing
        pulse(start_cont);
        cycles(30);
        check(words == 0, "R3 no pre-trigger data", words, 0);
        check(state == 2'd2, "R1 continuous code", state, 2);
        pulse(stop);
        cycles(3);
        check(state == 2'd0, "R7 idle stop", state, 0);

        // R4: disarmed trigger ignored; trig_reset discards a pending trigger
        clr_mon();
        total = 16'd1;
        arm = 1'b0;
        pulse(start_finite);
        pulse(ext_trig);
        cycles(30);
        check(words == 0, "R4 disarmed ignored", words, 0);
        check(state == 2'd1, "R1 finite code", state, 1);
        gen_en = 1'b0;
        cycles(3);
        arm = 1'b1;
        pulse(ext_trig);
        pulse(trig_reset);
        gen_en = 1'b1;
        cycles(30);
        check(words == 0, "R4 trig_reset discards", words, 0);
        pulse(ext_trig);
        cycles(30);
        check(words == 2 * BL, "R4 later trigger accepted", words, 2 * BL);
        check(state == 2'd0, "R6 single burst done", state, 0);

        // R11: trigger during a burst is counted and ignored
        clr_mon();
        pulse(start_cont);
        pulse(ext_trig);
        cycles(2);
        pulse(ext_trig);
        cycles(30);
        check(missed == 8'd1, "R11 missed count", missed, 1);
        check(words == 2 * BL, "R11 one burst only", words, 2 * BL);
        pulse(stop);
        cycles(3);
        pulse(start_finite);
        cycles(2);
        check(missed == '0, "R11 cleared on start", missed, 0);
        pulse(err_clear);

        // R7: stop mid-burst finishes the frame
        clr_mon();
        pulse(start_cont);
        pulse(ext_trig);
        cycles(4);
        pulse(stop);
        cycles(40);
        check(words == 2 * BL, "R7 whole frame", words, 2 * BL);
        check(state == 2'd0, "R7 idle after frame", state, 0);

        // R8/R10: overflow sticks in error until cleared
        clr_mon();
        fifo_full = 1'b1;
        pulse(start_cont);
        pulse(ext_trig);
        cycles(20);
        check(state == 2'd3, "R8 overflow error", state, 3);
        check(words == 1, "R8 single word before error", words, 1);
        fifo_full = 1'b0;
        pulse(ext_trig);
        cycles(20);
        check(state == 2'd3, "R10 error persists", state, 3);
        check(words == 1, "R10 no words in error", words, 1);
        pulse(err_clear);
        cycles(1);
        check(state == 2'd0, "R10 clear to idle", state, 0);

        // R9: underflow in continuous errors, in finite has no effect
        pulse(start_cont);
        fifo_empty = 1'b1; fifo_rd = 1'b1;
        cycles(3);
        check(state == 2'd3, "R9 underflow error", state, 3);
        fifo_empty = 1'b0; fifo_rd = 1'b0;
        pulse(err_clear);
        total = 16'd1;
        pulse(start_finite);
        fifo_empty = 1'b1; fifo_rd = 1'b1;
        cycles(5);
        check(state == 2'd1, "R9 finite unaffected", state, 1);
        fifo_empty = 1'b0; fifo_rd = 1'b0;
        pulse(err_clear);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule